// File: doc/BRIEF.md
# UART Receiver Mute Wakeup Controller

This block sits next to a UART receive shifter in a node on a shared serial bus. A master talks to many listeners, and only the listener being addressed should see the full message. Any other node can mute itself. While muted, it raises no receive status and no interrupt. The block decides when a node enters mute and when it leaves, and it gates the receive strobe, the interrupt request and the idle flag to match.

The controller takes these inputs:
- a bit-period tick;
- the sampled RX line;
- a character-done strobe with the received word;
- a mute enable, a wake-method select, a word-length code and the node's address;
- a mute request pulse from software.

It leaves mute in one of two ways:
- **Idle-line wake:** RX stays high for a whole frame. This wake does not raise the idle flag.
- **Address-mark wake:** a character arrives with its top data bit set, and its remaining low bits equal the node address.

An address character that does not match puts an active node into mute by itself.

Top module: `uart_mute_wake`

## Requirements
- R1: While `mute_en` is 0, the `mute_flag` output is 0 one cycle later, and `mute_req` has no effect.
- R2: A `mute_req` pulse sampled while `mute_en` is 1 makes `mute_flag` 1 in the next cycle. It takes priority over any wake event in the same cycle.
- R3: While `mute_flag` is 1, the following are suppressed, except for a matching address character that wakes the node (R6):
  - the `status_stb` pulse;
  - the `rx_irq` pulse;
  - a new setting of `idle_flag`.
- R4: With `wake_sel` = 0, an idle frame detected while muted clears `mute_flag` in the following cycle. It leaves `idle_flag` unchanged at 0.
- R5: An idle frame is RX held high for a fixed number of consecutive bit ticks:
  - `word_len` 2'b00 (8 data bits): 10 ticks;
  - `word_len` 2'b01 (9 data bits): 11 ticks;
  - `word_len` 2'b10 (7 data bits): 9 ticks;
  - `word_len` 2'b11: treated as 2'b00, so 10 ticks.
- R6: With `wake_sel` = 1, a character is an address when its top data bit is 1. The top bit is bit 7 for code 00 or 11, bit 8 for code 01 and bit 6 for code 10. Its data bits below that bit are compared with the same low bits of `node_addr`. A match while muted clears `mute_flag` and delivers that character on `status_stb`.
- R7: With `wake_sel` = 1 and `mute_en` = 1, a mismatching address character sets or keeps `mute_flag` and produces no `status_stb`. A non-address character received while muted keeps the node muted.
- R8: The idle counter restarts on any low RX sample. It advances only on `bit_tick`, and it reports at most one idle frame per unbroken high stretch.
- R9: When not muted, an idle frame sets `idle_flag` and pulses `rx_irq` for one cycle. `idle_flag` stays 1 until an `idle_clr` pulse.
- R10: When not muted, `char_done` gives a one-cycle `status_stb` and `rx_irq` in the next cycle.
- R11: After synchronous reset, `mute_flag`, `idle_flag`, `status_stb`, `rx_irq` and the idle counter are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| rx_line | input | 1 | Sampled RX level |
| char_done | input | 1 | Received character complete |
| char_data | input | DATA_W | Received data word, right-aligned |
| mute_en | input | 1 | Enables the mute function |
| wake_sel | input | 1 | 0 = idle-line wake, 1 = address-mark wake |
| word_len | input | 2 | 00 = 8 bits, 01 = 9 bits, 10 = 7 bits, 11 = 8 bits |
| node_addr | input | DATA_W-1 | This node's address |
| mute_req | input | 1 | Software request to enter mute |
| idle_clr | input | 1 | Clears idle_flag |
| mute_flag | output | 1 | Node is muted |
| status_stb | output | 1 | Gated receive-status strobe |
| rx_irq | output | 1 | Gated receive interrupt pulse |
| idle_flag | output | 1 | Sticky idle-line flag |

## Verification
The checker watches these rules on every cycle:
- mute clears when the block is disabled;
- a request mutes the node in the next cycle;
- a status strobe is held off while muted;
- the idle flag never rises while muted;
- a detected idle frame wakes an idle-line node;
- a low RX sample blocks an idle report;
- the idle flag stays set until cleared.

Other behaviours depend on a sequence of stimulus, so only the bench's scenarios can show them:
- the exact tick count of an idle frame for each word-length code;
- the single report per high stretch;
- the address-bit position and the low-bit compare for each code;
- automatic muting on a foreign address.

// File: rtl/uart_mute_pkg.sv
`timescale 1ns/1ps
package uart_mute_pkg;

    // Width of the idle tick counter; the longest frame is 11 ticks.
    localparam int CNT_W = 4;

    // Number of data bits selected by the word-length code (11 falls back to 8).
    function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] code);
        case (code)
            2'b01:   data_bits = CNT_W'(9);
            2'b10:   data_bits = CNT_W'(7);
            default: data_bits = CNT_W'(8);
        endcase
    endfunction

    // Idle frame length in bit ticks: start + data + stop.
    function automatic logic [CNT_W-1:0] frame_ticks(input logic [1:0] code);
        frame_ticks = data_bits(code) + CNT_W'(2);
    endfunction

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
        logic             hit;
    } idle_state_t;

    typedef struct packed {
        logic mute;
        logic idle;
        logic stb;
        logic irq;
    } ctl_state_t;

endpackage

// File: rtl/uart_idle_detect.sv
`timescale 1ns/1ps
module uart_idle_detect
    import uart_mute_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       rx_line,
    input  logic [1:0] word_len,
    output logic       idle_hit
);

    idle_state_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        st_d.hit = 1'b0;
        cnt_inc = st_q.cnt + CNT_W'(1);
        if (!rx_line) begin
            // Any low sample restarts the frame and re-arms the detector.
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (bit_tick && !st_q.fired) begin
            if (cnt_inc >= frame_ticks(word_len)) begin
                st_d.hit   = 1'b1;
                st_d.fired = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign idle_hit = st_q.hit;

endmodule

// File: rtl/uart_addr_match.sv
`timescale 1ns/1ps
module uart_addr_match
    import uart_mute_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic [DATA_W-1:0] char_data,
    input  logic [DATA_W-2:0] node_addr,
    input  logic [1:0]        word_len,
    output logic              is_addr,
    output logic              addr_match
);

    always_comb begin
        int nbits;
        nbits = int'(data_bits(word_len));
        if (nbits > DATA_W) nbits = DATA_W;
        is_addr    = 1'b0;
        addr_match = 1'b1;
        // The mark bit sits at the top of the active data field.
        for (int i = 0; i < DATA_W; i++) begin
            if (i == nbits - 1) is_addr = char_data[i];
        end
        // Only the bits below the mark take part in the compare.
        for (int i = 0; i < DATA_W - 1; i++) begin
            if (i < nbits - 1 && char_data[i] != node_addr[i]) addr_match = 1'b0;
        end
    end

endmodule

// File: rtl/uart_mute_wake.sv
`timescale 1ns/1ps
module uart_mute_wake
    import uart_mute_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              rx_line,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              mute_en,
    input  logic              wake_sel,
    input  logic [1:0]        word_len,
    input  logic [DATA_W-2:0] node_addr,
    input  logic              mute_req,
    input  logic              idle_clr,
    output logic              mute_flag,
    output logic              status_stb,
    output logic              rx_irq,
    output logic              idle_flag
);

    logic idle_hit;
    logic is_addr;
    logic addr_match;

    uart_idle_detect i_idle (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .rx_line  (rx_line),
        .word_len (word_len),
        .idle_hit (idle_hit)
    );

    uart_addr_match #(.DATA_W(DATA_W)) i_addr (
        .char_data  (char_data),
        .node_addr  (node_addr),
        .word_len   (word_len),
        .is_addr    (is_addr),
        .addr_match (addr_match)
    );

    ctl_state_t ctl_d, ctl_q;

    logic addr_ev, wake_idle, wake_addr, auto_mute, deliver, idle_set;

    always_comb begin
        ctl_d     = ctl_q;
        addr_ev   = wake_sel && char_done && is_addr;
        wake_idle = ctl_q.mute && !wake_sel && idle_hit;
        wake_addr = ctl_q.mute && addr_ev && addr_match;
        auto_mute = mute_en && addr_ev && !addr_match;
        deliver   = char_done && (!ctl_q.mute || wake_addr) && !auto_mute;
        idle_set  = idle_hit && !ctl_q.mute;

        if (!mute_en)                     ctl_d.mute = 1'b0;
        else if (mute_req)                ctl_d.mute = 1'b1;
        else if (wake_idle || wake_addr)  ctl_d.mute = 1'b0;
        else if (auto_mute)               ctl_d.mute = 1'b1;

        if (idle_clr) ctl_d.idle = 1'b0;
        if (idle_set) ctl_d.idle = 1'b1;

        ctl_d.stb = deliver;
        ctl_d.irq = deliver || idle_set;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign mute_flag  = ctl_q.mute;
    assign idle_flag  = ctl_q.idle;
    assign status_stb = ctl_q.stb;
    assign rx_irq     = ctl_q.irq;

endmodule

// File: rtl/uart_mute_checker.sv
`timescale 1ns/1ps
module uart_mute_checker (
    input logic clk,
    input logic rst,
    input logic mute_en,
    input logic mute_req,
    input logic wake_sel,
    input logic char_done,
    input logic rx_line,
    input logic idle_clr,
    input logic idle_hit,
    input logic mute_flag,
    input logic status_stb,
    input logic rx_irq,
    input logic idle_flag
);

    assert_disable_clears_R1: assert property (@(posedge clk) disable iff (rst)
        !mute_en |=> !mute_flag);

    assert_request_mutes_R2: assert property (@(posedge clk) disable iff (rst)
        mute_en && mute_req |=> mute_flag);

    assert_no_status_muted_R3: assert property (@(posedge clk) disable iff (rst)
        mute_flag && !(char_done && wake_sel) |=> !status_stb);

    assert_no_idle_rise_muted_R3: assert property (@(posedge clk) disable iff (rst)
        mute_flag |=> !$rose(idle_flag));

    assert_idle_wakes_R4: assert property (@(posedge clk) disable iff (rst)
        mute_en && !mute_req && !wake_sel && mute_flag && idle_hit |=> !mute_flag);

    assert_low_blocks_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !rx_line |=> !idle_hit);

    assert_idle_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        idle_flag && !idle_clr |=> idle_flag);

    assert_irq_with_status_R10: assert property (@(posedge clk) disable iff (rst)
        status_stb |-> rx_irq);

endmodule

bind uart_mute_wake uart_mute_checker i_chk (.*);

// File: tb/test_uart_mute_wake.sv
`timescale 1ns/1ps
module test_uart_mute_wake;

    logic       clk = 1'b0;
    logic       rst, bit_tick, rx_line, char_done, mute_en, wake_sel, mute_req, idle_clr;
    logic [8:0] char_data;
    logic [1:0] word_len;
    logic [7:0] node_addr;
    logic       mute_flag, status_stb, rx_irq, idle_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_mute_wake #(.DATA_W(9)) i_uart_mute_wake (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_line(rx_line),
        .char_done(char_done), .char_data(char_data), .mute_en(mute_en),
        .wake_sel(wake_sel), .word_len(word_len), .node_addr(node_addr),
        .mute_req(mute_req), .idle_clr(idle_clr), .mute_flag(mute_flag),
        .status_stb(status_stb), .rx_irq(rx_irq), .idle_flag(idle_flag)
    );

    // {word_len[1:0], data[8:0], start_muted, exp_mute, exp_stb}; node address 8'h25, wake_sel=1
    localparam logic [13:0] VEC [11] = '{
        {2'b00, 9'h0A5, 1'b1, 1'b0, 1'b1},  // R6 matching address, code 00
        {2'b00, 9'h0A4, 1'b1, 1'b1, 1'b0},  // R7 foreign address stays muted
        {2'b00, 9'h025, 1'b1, 1'b1, 1'b0},  // R7 plain data while muted
        {2'b00, 9'h025, 1'b0, 1'b0, 1'b1},  // R10 plain data when active
        {2'b00, 9'h0A4, 1'b0, 1'b1, 1'b0},  // R7 foreign address auto-mutes
        {2'b01, 9'h125, 1'b1, 1'b0, 1'b1},  // R6 mark on bit 8, code 01
        {2'b01, 9'h0A5, 1'b1, 1'b1, 1'b0},  // R7 bit 8 clear, not an address
        {2'b10, 9'h065, 1'b1, 1'b0, 1'b1},  // R6 mark on bit 6, code 10
        {2'b10, 9'h0A5, 1'b1, 1'b1, 1'b0},  // R7 bit 6 clear, code 10
        {2'b11, 9'h0A5, 1'b1, 1'b0, 1'b1},  // R6 code 11 acts as code 00
        {2'b01, 9'h1A5, 1'b0, 1'b1, 1'b0}   // R7 low 8 bits differ, code 01
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            bit_tick = 1'b1; step();
            bit_tick = 1'b0; step();
        end
    endtask

    task automatic rx_break();
        rx_line = 1'b0; step();
        rx_line = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; bit_tick = 1'b0; rx_line = 1'b1; char_done = 1'b0; char_data = '0;
        mute_en = 1'b0; wake_sel = 1'b0; word_len = 2'b00; node_addr = 8'h25;
        mute_req = 1'b0; idle_clr = 1'b0;
        repeat (3) step();
        chk("R11 mute after reset", mute_flag, 0);
        chk("R11 idle after reset", idle_flag, 0);
        chk("R11 strobes after reset", {status_stb, rx_irq}, 0);
        rst = 1'b0;
        rx_break();

        // R1: request ignored while disabled
        mute_req = 1'b1; step(); mute_req = 1'b0;
        chk("R1 request ignored", mute_flag, 0);

        // R2: request sets mute next cycle
        mute_en = 1'b1; mute_req = 1'b1; step(); mute_req = 1'b0;
        chk("R2 mute set", mute_flag, 1);

        // R3: character while muted is swallowed
        char_done = 1'b1; char_data = 9'h0A5; step(); char_done = 1'b0;
        chk("R3 status gated", {status_stb, rx_irq}, 0);

        // R5 / R4: one tick short keeps mute, full frame wakes without IDLE
        rx_break();
        ticks(9);
        chk("R5 9 ticks too short", mute_flag, 1);
        ticks(1);
        chk("R4 idle wake clears mute", mute_flag, 0);
        chk("R4 no idle flag on wake", idle_flag, 0);

        // R8: no second report in the same high stretch
        ticks(12);
        chk("R8 single report", idle_flag, 0);

        // R9: idle frame when active sets sticky flag with irq pulse
        rx_break();
        ticks(10);
        chk("R9 idle flag set", idle_flag, 1);
        chk("R9 irq pulse", rx_irq, 1);
        step();
        chk("R9 irq one cycle", rx_irq, 0);
        step();
        chk("R9 flag held", idle_flag, 1);
        idle_clr = 1'b1; step(); idle_clr = 1'b0;
        chk("R9 flag cleared", idle_flag, 0);

        // R8: low sample mid-count restarts the count
        rx_break();
        ticks(5);
        rx_break();
        ticks(5);
        chk("R8 restart on low", idle_flag, 0);
        ticks(5);
        chk("R8 full after restart", idle_flag, 1);
        idle_clr = 1'b1; step(); idle_clr = 1'b0;

        // R8: ticks are the only thing that advances the count
        rx_break();
        repeat (30) step();
        chk("R8 no count without ticks", idle_flag, 0);

        // R5: frame lengths per word-length code
        word_len = 2'b01; rx_break();
        ticks(10);
        chk("R5 code01 at 10", idle_flag, 0);
        ticks(1);
        chk("R5 code01 at 11", idle_flag, 1);
        idle_clr = 1'b1; step(); idle_clr = 1'b0;
        word_len = 2'b10; rx_break();
        ticks(8);
        chk("R5 code10 at 8", idle_flag, 0);
        ticks(1);
        chk("R5 code10 at 9", idle_flag, 1);
        idle_clr = 1'b1; step(); idle_clr = 1'b0;
        word_len = 2'b11; rx_break();
        ticks(9);
        chk("R5 code11 at 9", idle_flag, 0);
        ticks(1);
        chk("R5 code11 at 10", idle_flag, 1);
        idle_clr = 1'b1; step(); idle_clr = 1'b0;
        word_len = 2'b00;

        // R3 / R7: address wake ignores idle frames and leaves IDLE alone
        wake_sel = 1'b1; mute_req = 1'b1; step(); mute_req = 1'b0;
        rx_break();
        ticks(10);
        chk("R7 idle does not wake address mode", mute_flag, 1);
        chk("R3 idle flag gated", idle_flag, 0);

        // R1: disabling clears an existing mute
        mute_en = 1'b0; step();
        chk("R1 disable clears mute", mute_flag, 0);
        mute_en = 1'b1;

        // R10: active character delivered for exactly one cycle
        wake_sel = 1'b0;
        char_done = 1'b1; char_data = 9'h011; step(); char_done = 1'b0;
        chk("R10 status strobe", {status_stb, rx_irq}, 2'b11);
        step();
        chk("R10 strobe one cycle", status_stb, 0);

        // R6 / R7: vector table in address-mark mode
        wake_sel = 1'b1;
        for (int v = 0; v < 11; v++) begin
            mute_en = 1'b0; step();
            mute_en = 1'b1; mute_req = VEC[v][2]; step(); mute_req = 1'b0;
            word_len  = VEC[v][13:12];
            char_data = VEC[v][11:3];
            char_done = 1'b1; step(); char_done = 1'b0;
            chk($sformatf("R6/R7 vec%0d mute", v), mute_flag, VEC[v][1]);
            chk($sformatf("R6/R7 vec%0d strobe", v), status_stb, VEC[v][0]);
        end

        finish_run();
    end

endmodule